// File: doc/BRIEF.md
# Programmable Tap-Select Interval Timer

This block divides a clock-enable tick by a selectable power of two. The tick stands in for a slow oscillator. Sixteen binary stages advance synchronously, one step per tick. A two-bit select picks which stage drives the timing output. One select code reroutes the upper eight stages so they advance on every tick. That gives a short period from the top stage.

The output can run in two ways. It can be a free-running square wave at the selected division. Or it can be a single timed interval that flips the output once, after half the selected period, and then holds. A polarity input sets the idle level of the output in both modes. The count is cleared by a master clear input or by a power-on request, and the power-on path can be enabled or disabled. A change in the level of the mode input restarts the interval.

Top module: `tap_timer`

## Requirements
- R1: While no clear is active, the stage count advances by exactly one on each clock edge where `tick` is 1 and keeps its value on edges where `tick` is 0.
- R2: The select code `{sel_a,sel_b}` maps to stages as follows: 2'b00 taps stage 13 (period 2^13 ticks), 2'b01 taps stage 10 (period 2^10), 2'b11 taps stage 16 (period 2^16).
- R3: With `{sel_a,sel_b}` = 2'b10 the upper eight stages (9 to 16) advance on every tick instead of on the carry out of stage 8, and stage 16 is tapped, so the output period is 2^8 ticks.
- R4: `mrst` = 1 clears all sixteen stages at the next clock edge, whatever the count, and takes priority over a tick in the same cycle.
- R5: When `auto_rst_n` = 0, `por_n` = 0 clears the count like `mrst`; when `auto_rst_n` = 1, `por_n` has no effect on the count or the output.
- R6: In any cycle in which a clear is active (master clear, enabled power-on request, or a mode level change), `tmr_out` equals `pol`.
- R7: With `mode` = 1, `tmr_out` equals bit n-1 of the tick count since the last clear, XOR `pol`, where 2^n is the selected period. It is a square wave repeating every 2^n ticks.
- R8: With `mode` = 0, `tmr_out` equals `pol` until 2^(n-1) ticks have been counted after a clear. From then on it equals the inverse of `pol` for all later ticks, until the next clear.
- R9: A change in the level of `mode` counts as a clear in the cycle where it appears. The count and the one-shot hold are cleared on the next edge, and the interval restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master clear, active high, synchronous |
| auto_rst_n | input | 1 | 0 enables the power-on clear path |
| por_n | input | 1 | Power-on request, active low |
| tick | input | 1 | Count enable, one pulse per oscillator period |
| sel_a | input | 1 | Time select, high bit |
| sel_b | input | 1 | Time select, low bit |
| pol | input | 1 | Output polarity / idle level |
| mode | input | 1 | 1 = continuous square wave, 0 = single interval |
| tmr_out | output | 1 | Timing output |

## Verification
A tick and a clear can arrive in the same cycle. The clear may come from `mrst` or from a flip of `mode`. If the increment wins instead of the clear, the following interval is shifted by one tick. The bench brings the count to one tick short of the threshold. It then raises `mrst` together with `tick`, releases the clear, and checks that 2^(n-1)-1 further ticks leave the output idle while one more tick flips it. The same edge-exact judgement is applied after a mode flip that re-arms a latched one-shot.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  typedef enum logic [1:0] {
    SEL_MID   = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_FAST  = 2'b10,
    SEL_LONG  = 2'b11
  } tap_sel_e;

  // Stage number (1-based) tapped for a select code.
  function automatic int unsigned tap_stage(input tap_sel_e sel,
                                            input int unsigned s_mid,
                                            input int unsigned s_short,
                                            input int unsigned s_top);
    case (sel)
      SEL_MID:   return s_mid;
      SEL_SHORT: return s_short;
      default:   return s_top;
    endcase
  endfunction

  // log2 of the output period in ticks for a select code.
  function automatic int unsigned period_log2(input tap_sel_e sel,
                                              input int unsigned s_mid,
                                              input int unsigned s_short,
                                              input int unsigned s_top,
                                              input int unsigned split);
    if (sel == SEL_FAST) return s_top - split;
    return tap_stage(sel, s_mid, s_short, s_top);
  endfunction

endpackage

// File: rtl/tap_timer_counter.sv
module tap_timer_counter #(
  parameter int unsigned STAGES = 16,
  parameter int unsigned SPLIT  = 8
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              tick,
  input  logic              bypass,
  output logic [STAGES-1:0] cnt,
  output logic              lo_carry
);
  localparam int unsigned HI_W = STAGES - SPLIT;

  logic [SPLIT-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             hi_step;

  assign lo_carry = tick & (&lo_q);
  assign hi_step  = bypass ? tick : lo_carry;

  always_ff @(posedge clk) begin
    if (clear) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (tick)    lo_q <= lo_q + 1'b1;
      if (hi_step) hi_q <= hi_q + 1'b1;
    end
  end

  assign cnt = {hi_q, lo_q};
endmodule

// File: rtl/tap_timer_mux.sv
module tap_timer_mux
  import tap_timer_pkg::*;
#(
  parameter int unsigned STAGES  = 16,
  parameter int unsigned S_MID   = 13,
  parameter int unsigned S_SHORT = 10
) (
  input  tap_sel_e          sel,
  input  logic [STAGES-1:0] cnt,
  output logic              tap
);
  always_comb begin
    tap = cnt[tap_stage(sel, S_MID, S_SHORT, STAGES) - 1];
  end
endmodule

// File: rtl/tap_timer_oneshot.sv
module tap_timer_oneshot (
  input  logic clk,
  input  logic clear,
  input  logic tap,
  output logic latched,
  output logic level
);
  always_ff @(posedge clk) begin
    if (clear) latched <= 1'b0;
    else       latched <= latched | tap;
  end

  assign level = latched | tap;
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int unsigned STAGES  = 16,
  parameter int unsigned SPLIT   = 8,
  parameter int unsigned S_MID   = 13,
  parameter int unsigned S_SHORT = 10
) (
  input  logic clk,
  input  logic mrst,
  input  logic auto_rst_n,
  input  logic por_n,
  input  logic tick,
  input  logic sel_a,
  input  logic sel_b,
  input  logic pol,
  input  logic mode,
  output logic tmr_out
);
  tap_sel_e          sel;
  logic              bypass;
  logic              mode_q;
  logic              mode_chg;
  logic              por_hit;
  logic              clear;
  logic [STAGES-1:0] cnt;
  logic              lo_carry;
  logic              tap;
  logic              latched;
  logic              shot_level;
  logic              state;

  assign sel      = tap_sel_e'({sel_a, sel_b});
  assign bypass   = (sel == SEL_FAST);
  assign mode_chg = mode ^ mode_q;
  assign por_hit  = ~auto_rst_n & ~por_n;
  assign clear    = mrst | por_hit | mode_chg;

  always_ff @(posedge clk) mode_q <= mode;

  tap_timer_counter #(.STAGES(STAGES), .SPLIT(SPLIT)) u_cnt (
    .clk(clk), .clear(clear), .tick(tick), .bypass(bypass),
    .cnt(cnt), .lo_carry(lo_carry)
  );

  tap_timer_mux #(.STAGES(STAGES), .S_MID(S_MID), .S_SHORT(S_SHORT)) u_mux (
    .sel(sel), .cnt(cnt), .tap(tap)
  );

  tap_timer_oneshot u_shot (
    .clk(clk), .clear(clear), .tap(tap),
    .latched(latched), .level(shot_level)
  );

  assign state   = mode ? tap : shot_level;
  assign tmr_out = (clear ? 1'b0 : state) ^ pol;
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk #(
  parameter int unsigned STAGES = 16,
  parameter int unsigned SPLIT  = 8
) (
  input logic              clk,
  input logic              clear,
  input logic              tick,
  input logic              bypass,
  input logic              mode,
  input logic              pol,
  input logic [STAGES-1:0] cnt,
  input logic              lo_carry,
  input logic              tap,
  input logic              latched,
  input logic              tmr_out
);
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clear |=> (cnt == '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk)
    (!tick && !clear) |=> $stable(cnt)); // R1

  AST_FAST_UPPER: assert property (@(posedge clk)
    (tick && !clear && bypass) |=>
      (cnt[STAGES-1:SPLIT] == $past(cnt[STAGES-1:SPLIT]) + 1'b1)); // R3

  AST_CARRY_UPPER: assert property (@(posedge clk)
    (lo_carry && !clear && !bypass) |=>
      (cnt[STAGES-1:SPLIT] == $past(cnt[STAGES-1:SPLIT]) + 1'b1)); // R2

  AST_SHOT_HOLD: assert property (@(posedge clk)
    (!clear && !mode && latched) |=> latched); // R8

  AST_CLEAR_LEVEL: assert property (@(posedge clk)
    clear |-> (tmr_out == pol)); // R6

  AST_WAVE_TAP: assert property (@(posedge clk)
    (!clear && mode) |-> (tmr_out == (tap ^ pol))); // R7
endmodule

bind tap_timer tap_timer_chk #(.STAGES(STAGES), .SPLIT(SPLIT)) u_chk (
  .clk(clk), .clear(clear), .tick(tick), .bypass(bypass), .mode(mode),
  .pol(pol), .cnt(cnt), .lo_carry(lo_carry), .tap(tap),
  .latched(latched), .tmr_out(tmr_out)
);

// File: tb/tap_timer_tb.sv
module tap_timer_tb;
  logic clk = 1'b0;
  logic mrst = 1'b1, auto_rst_n = 1'b0, por_n = 1'b0, tick = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, pol = 1'b0, mode = 1'b1;
  logic tmr_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tap_timer u_dut (
    .clk(clk), .mrst(mrst), .auto_rst_n(auto_rst_n), .por_n(por_n),
    .tick(tick), .sel_a(sel_a), .sel_b(sel_b), .pol(pol), .mode(mode),
    .tmr_out(tmr_out)
  );

  typedef struct packed {
    logic        a, b, p, m;
    logic [16:0] n;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0,1'b0,1'b0,1'b1,17'd4095, 1'b0,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,17'd4096, 1'b1,4'd2},
    '{1'b0,1'b1,1'b0,1'b1,17'd512,  1'b1,4'd2},
    '{1'b0,1'b1,1'b0,1'b1,17'd1024, 1'b0,4'd7},
    '{1'b1,1'b0,1'b1,1'b1,17'd128,  1'b0,4'd3},
    '{1'b1,1'b0,1'b1,1'b1,17'd256,  1'b1,4'd3},
    '{1'b1,1'b1,1'b0,1'b1,17'd32768,1'b1,4'd2},
    '{1'b0,1'b1,1'b0,1'b0,17'd511,  1'b0,4'd8},
    '{1'b0,1'b1,1'b0,1'b0,17'd1024, 1'b1,4'd8},
    '{1'b0,1'b1,1'b1,1'b0,17'd1024, 1'b0,4'd8},
    '{1'b1,1'b0,1'b0,1'b0,17'd300,  1'b1,4'd3},
    '{1'b1,1'b1,1'b1,1'b1,17'd32767,1'b1,4'd7}
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (tmr_out !== exp) begin
      errors++;
      $display("FAIL %s: tmr_out=%b expected=%b", req, tmr_out, exp);
    end
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_clear();
    mrst = 1'b1;
    @(negedge clk);
    mrst = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    auto_rst_n = 1'b1;
    // R6: reset level follows pol
    #1 check("R6 reset level pol=0", 1'b0);
    pol = 1'b1;
    #1 check("R6 reset level pol=1", 1'b1);
    @(negedge clk);
    mrst = 1'b0;
    pol = 1'b0;

    // Table of select / mode / polarity vectors (R2 R3 R7 R8)
    for (int i = 0; i < 12; i++) begin
      sel_a = VEC[i].a; sel_b = VEC[i].b; pol = VEC[i].p; mode = VEC[i].m;
      @(negedge clk);
      pulse_clear();
      run(int'(VEC[i].n));
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
    end

    // R1: tick gating holds the count
    sel_a = 1'b0; sel_b = 1'b1; pol = 1'b0; mode = 1'b1;
    @(negedge clk);
    pulse_clear();
    run(511);
    repeat (50) @(negedge clk);
    check("R1 hold without tick", 1'b0);
    run(1);
    check("R1 single tick advance", 1'b1);

    // R5: disabled power-on path is ignored, enabled one clears
    auto_rst_n = 1'b1; por_n = 1'b0;
    #1 check("R5 por ignored same cycle", 1'b1);
    @(negedge clk);
    por_n = 1'b1;
    check("R5 por ignored count kept", 1'b1);
    auto_rst_n = 1'b0; por_n = 1'b0;
    #1 check("R5 por enabled clears", 1'b0);
    @(negedge clk);
    por_n = 1'b1; auto_rst_n = 1'b1;
    run(511);
    check("R5 count restarted after por", 1'b0);

    // R4: clear wins over a simultaneous tick
    pulse_clear();
    run(511);
    mrst = 1'b1; tick = 1'b1;
    @(negedge clk);
    mrst = 1'b0; tick = 1'b0;
    check("R4 clear beats tick", 1'b0);
    run(511);
    check("R4 one short after clear", 1'b0);
    run(1);
    check("R4 threshold after clear", 1'b1);

    // R9: mode flip re-arms a latched one-shot
    mode = 1'b0;
    @(negedge clk);
    run(1024);
    check("R8 latched one-shot", 1'b1);
    mode = 1'b1;
    #1 check("R9 mode flip clears output", 1'b0);
    @(negedge clk);
    mode = 1'b0;
    @(negedge clk);
    run(511);
    check("R9 re-armed one short", 1'b0);
    run(1);
    check("R9 re-armed threshold", 1'b1);
    run(2000);
    check("R8 holds after many ticks", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule